// File: doc/BRIEF.md
# RTC Capture/Compare Channel

This block is a single capture/compare channel that sits beside a free-running real-time counter. The counter logic lives elsewhere: the channel receives the current 32-bit main count and the 15-bit pre-count as inputs, together with an asynchronous capture pin, a 7-bit control word and a write port for its stored compare value.

In compare mode the channel watches either the main count or the pre-count. When that count steps onto the stored value, the channel raises a one-clock event and applies one of four actions to its output pin. In capture mode the pin is synchronized and edge-detected. On the selected edge the channel latches the main count into a read-only capture register and raises the same one-clock event. An interrupt controller outside the block consumes the event.

Top module: `rtc_cc_channel`

## Requirements
- R1: While reset is low at a clock edge, the output pin, the event and the capture value all read zero after that edge.
- R2: Control bits [1:0] select the function: 0 off, 1 capture, 2 compare, 3 treated as off. Whenever the function is not compare, the output pin is driven low one clock later. In off (0 or 3) no event is produced.
- R3: In compare mode, if the selected count takes a new value equal to the stored compare value, the event is high for the clock cycle after that step.
- R4: A match fires only on the step that reaches the value. A count that holds at the compare value produces no further event, and writing a compare value equal to an unchanging count produces none.
- R5: Control bit 4 selects the compared quantity: 0 the 32-bit main count, 1 the pre-count. With the pre-count selected, only the low 15 bits of the compare value take part, and changes of the main count produce no event.
- R6: Action 0 (control bits [3:2]) pulses the output: it is high for exactly the one clock in which the event is high, and low otherwise.
- R7: Action 1 inverts the output on each match, action 2 drives it low and action 3 drives it high. Between matches the output keeps its level.
- R8: In capture mode the pin passes two synchronizer flops and an edge register. The event and the new capture value appear after the third clock edge following a pin change. The captured value is the main count at that edge. Edge select (control bits [6:5]) 0 captures rising, 1 falling, 2 both.
- R9: Edge select 3 never captures: the capture value stays unchanged and no event is raised for any pin activity.
- R10: The control word layout is function [1:0], action [3:2], base [4], edge [6:5]. The compare value is loaded from the write port on the clock edge at which the write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 7 | Function, action, base and edge select |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | 32 | Compare value write data |
| main_cnt | input | 32 | Current main count |
| pre_cnt | input | 15 | Current pre-count |
| cap_pin | input | 1 | Asynchronous capture input |
| cc_out | output | 1 | Compare output pin |
| cc_event | output | 1 | One-clock match or capture event |
| cap_value | output | 32 | Last captured main count |

## Verification
The hardest case to reach is a held count. A count that sits on the compare value has to stay silent, and so does a compare value written onto a count that is not moving. These are reached by parking the main count on a value for several clocks and then rewriting the compare register to that same value. The bench then steps the count away and back to prove the detector recovers. Capture latency is probed by changing the pin on a negative edge and checking the event on each of the following three clocks. A behavioural model with a queue-based synchronizer runs beside the design and is compared every cycle.

// File: rtl/rtc_cc_pkg.sv
// Shared types for the RTC capture/compare channel.
// Assumes the control word is 7 bits with the field order used below.
package rtc_cc_pkg;

    typedef enum logic [1:0] {
        FN_OFF     = 2'd0,
        FN_CAPTURE = 2'd1,
        FN_COMPARE = 2'd2,
        FN_SPARE   = 2'd3
    } cc_func_e;

    typedef enum logic [1:0] {
        ACT_PULSE  = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } cc_act_e;

    typedef enum logic [1:0] {
        EDG_RISE = 2'd0,
        EDG_FALL = 2'd1,
        EDG_BOTH = 2'd2,
        EDG_NONE = 2'd3
    } cc_edge_e;

    typedef struct packed {
        cc_edge_e edge_sel;   // [6:5]
        logic     base_pre;   // [4]
        cc_act_e  action;     // [3:2]
        cc_func_e func;       // [1:0]
    } cc_ctrl_t;

endpackage

// File: rtl/rtc_cc_step_match.sv
// Step-match detector: flags a count that has just changed onto a reference.
// Assumes the count is sampled once per clock; a held count never re-fires.
module rtc_cc_step_match #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] ref_val,
    output logic         hit
);

    logic [W-1:0] prev_q;

    // Remember the count seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cnt;
    end

    // A hit needs both a fresh step and equality.
    always_comb begin
        hit = (cnt != prev_q) && (cnt == ref_val);
    end

endmodule

// File: rtl/rtc_cc_edge_detect.sv
// Capture-pin conditioner: a synchronizer chain followed by edge selection.
// Assumes the pin is asynchronous; SYNC_STAGES must be at least 2.
module rtc_cc_edge_detect
    import rtc_cc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin,
    input  cc_edge_e edge_sel,
    output logic     fire
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   dly_q;
    logic                   lvl;
    logic                   rise;
    logic                   fall;

    // Shift the pin through the synchronizer and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            dly_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            dly_q  <= sync_q[SYNC_STAGES-1];
        end
    end

    // Decode the configured edge from the synchronized level.
    always_comb begin
        lvl  = sync_q[SYNC_STAGES-1];
        rise = lvl & ~dly_q;
        fall = ~lvl & dly_q;
        unique case (edge_sel)
            EDG_RISE: fire = rise;
            EDG_FALL: fire = fall;
            EDG_BOTH: fire = rise | fall;
            default:  fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/rtc_cc_out_drive.sv
// Output pin driver: applies the selected action on a compare match.
// Assumes match is already qualified; pin is forced low outside compare.
module rtc_cc_out_drive
    import rtc_cc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cc_func_e func,
    input  cc_act_e  action,
    input  logic     match,
    output logic     pin_q
);

    // Update the pin level from the action and the match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (func != FN_COMPARE) begin
            pin_q <= 1'b0;
        end else begin
            unique case (action)
                ACT_PULSE:  pin_q <= match;
                ACT_TOGGLE: pin_q <= pin_q ^ match;
                ACT_CLEAR:  pin_q <= match ? 1'b0 : pin_q;
                default:    pin_q <= match ? 1'b1 : pin_q;
            endcase
        end
    end

endmodule

// File: rtl/rtc_cc_channel.sv
// RTC capture/compare channel top.
// Holds the compare and capture registers, selects the compared count and
// merges match or capture into a one-clock event. Assumes the counters are
// synchronous to clk and driven from outside.
module rtc_cc_channel
    import rtc_cc_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PRE_W       = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [6:0]       ctrl_word,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic [CNT_W-1:0] main_cnt,
    input  logic [PRE_W-1:0] pre_cnt,
    input  logic             cap_pin,
    output logic             cc_out,
    output logic             cc_event,
    output logic [CNT_W-1:0] cap_value
);

    localparam int CTRL_W = $bits(cc_ctrl_t);

    cc_ctrl_t         ctrl;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cap_q;
    logic             evt_q;
    logic             hit_main;
    logic             hit_pre;
    logic             hit_sel;
    logic             edge_fire;

    // Interpret the raw control bits as typed fields.
    always_comb begin
        ctrl = cc_ctrl_t'(ctrl_word[CTRL_W-1:0]);
    end

    // Load the compare value from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_we) cmp_q <= cmp_wdata;
    end

    rtc_cc_step_match #(.W(CNT_W)) u_main_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (main_cnt),
        .ref_val (cmp_q),
        .hit     (hit_main)
    );

    rtc_cc_step_match #(.W(PRE_W)) u_pre_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (pre_cnt),
        .ref_val (cmp_q[PRE_W-1:0]),
        .hit     (hit_pre)
    );

    // Pick the match of the configured base.
    always_comb begin
        hit_sel = ctrl.base_pre ? hit_pre : hit_main;
    end

    rtc_cc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (cap_pin),
        .edge_sel (ctrl.edge_sel),
        .fire     (edge_fire)
    );

    rtc_cc_out_drive u_drive (
        .clk    (clk),
        .rst_n  (rst_n),
        .func   (ctrl.func),
        .action (ctrl.action),
        .match  (hit_sel),
        .pin_q  (cc_out)
    );

    // Latch the main count on a qualified capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   cap_q <= '0;
        else if (ctrl.func == FN_CAPTURE && edge_fire) cap_q <= main_cnt;
    end

    // Raise the one-clock event from whichever function is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else begin
            unique case (ctrl.func)
                FN_COMPARE: evt_q <= hit_sel;
                FN_CAPTURE: evt_q <= edge_fire;
                default:    evt_q <= 1'b0;
            endcase
        end
    end

    assign cc_event  = evt_q;
    assign cap_value = cap_q;

endmodule

// File: rtl/rtc_cc_channel_chk.sv
// Property checker for rtc_cc_channel, attached by bind.
// Assumes the control word field order of the top module.
module rtc_cc_channel_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [6:0]       ctrl_word,
    input logic             cc_out,
    input logic             cc_event,
    input logic [CNT_W-1:0] cap_value
);

    logic [1:0] fn;
    logic [1:0] act;
    logic [1:0] edg;

    // Split the control word for readability of the properties.
    always_comb begin
        fn  = ctrl_word[1:0];
        act = ctrl_word[3:2];
        edg = ctrl_word[6:5];
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!cc_out && !cc_event && cap_value == '0));

    a_r2_pin_low_off_compare: assert property (@(posedge clk) disable iff (!rst_n)
        (fn != 2'd2) |=> !cc_out);

    a_r2_off_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == 2'd0 || fn == 2'd3) |=> !cc_event);

    a_r6_pulse_tracks_event: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == 2'd2 && act == 2'd0) |=> (cc_out == cc_event));

    a_r7_set_holds_high: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == 2'd2 && act == 2'd3 && cc_out) |=> cc_out);

    a_r7_clear_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == 2'd2 && act == 2'd2 && !cc_out) |=> !cc_out);

    a_r8_capture_moves_with_event: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_value) |-> cc_event);

    a_r9_none_never_captures: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == 2'd1 && edg == 2'd3) |=> ($stable(cap_value) && !cc_event));

endmodule

bind rtc_cc_channel rtc_cc_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_word (ctrl_word),
    .cc_out    (cc_out),
    .cc_event  (cc_event),
    .cap_value (cap_value)
);

// File: tb/rtc_cc_channel_bench.sv
// Bench for rtc_cc_channel: directed stimulus plus a behavioural model
// compared on every negative clock edge.
module rtc_cc_channel_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  ctrl_word;
    logic        cmp_we;
    logic [31:0] cmp_wdata;
    logic [31:0] main_cnt;
    logic [14:0] pre_cnt;
    logic        cap_pin;
    logic        cc_out;
    logic        cc_event;
    logic [31:0] cap_value;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_cc_channel u_rtc_cc_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_word (ctrl_word),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .main_cnt  (main_cnt),
        .pre_cnt   (pre_cnt),
        .cap_pin   (cap_pin),
        .cc_out    (cc_out),
        .cc_event  (cc_event),
        .cap_value (cap_value)
    );

    // ---------------- behavioural reference model ----------------
    bit          live = 0;
    bit          m_out = 0;
    bit          m_evt = 0;
    longint      m_cap = 0;
    longint      m_cmp = 0;
    longint      m_pmain = 0;
    int          m_ppre = 0;
    bit          m_sync[$];

    always @(posedge clk) begin
        int  fn, act, base, edg;
        bit  hit, det, rise, fall;
        if (!rst_n) begin
            live = 1; m_out = 0; m_evt = 0; m_cap = 0; m_cmp = 0;
            m_pmain = 0; m_ppre = 0; m_sync = '{0, 0, 0};
        end else begin
            fn   = ctrl_word[1:0];
            act  = ctrl_word[3:2];
            base = ctrl_word[4];
            edg  = ctrl_word[6:5];
            if (base == 1) hit = (pre_cnt != m_ppre) && (pre_cnt == (m_cmp % 32768));
            else           hit = (main_cnt != m_pmain) && (main_cnt == m_cmp);
            rise = m_sync[1] && !m_sync[2];
            fall = !m_sync[1] && m_sync[2];
            det  = (edg == 0) ? rise : (edg == 1) ? fall : (edg == 2) ? (rise || fall) : 0;
            if (fn == 2) begin
                m_evt = hit;
                if (act == 0)      m_out = hit;
                else if (act == 1) m_out = m_out ^ hit;
                else if (hit)      m_out = (act == 3);
            end else if (fn == 1) begin
                m_evt = det;
                m_out = 0;
                if (det) m_cap = main_cnt;
            end else begin
                m_evt = 0;
                m_out = 0;
            end
            m_pmain = main_cnt;
            m_ppre  = pre_cnt;
            if (cmp_we) m_cmp = cmp_wdata;
            m_sync.push_front(cap_pin);
            void'(m_sync.pop_back());
        end
    end

    task automatic chk(input string req, input string what,
                       input longint act_v, input longint exp_v);
        total++;
        if (act_v != exp_v) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act_v, exp_v, $time);
        end
    endtask

    // Model comparison every cycle: output vs R7, event vs R3, capture vs R8.
    always @(negedge clk) begin
        if (live) begin
            chk("R7", "model cc_out",    cc_out,    m_out);
            chk("R3", "model cc_event",  cc_event,  m_evt);
            chk("R8", "model cap_value", cap_value, m_cap);
        end
    end

    task automatic step(input logic [31:0] m, input logic [14:0] p);
        main_cnt = m;
        pre_cnt  = p;
        @(negedge clk);
    endtask

    task automatic wr_cmp(input logic [31:0] v);
        cmp_we = 1'b1; cmp_wdata = v;
        @(negedge clk);
        cmp_we = 1'b0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst_n = 1'b0; ctrl_word = 7'h00; cmp_we = 1'b0; cmp_wdata = '0;
        main_cnt = '0; pre_cnt = '0; cap_pin = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "reset out", cc_out, 0);
        chk("R1", "reset event", cc_event, 0);
        chk("R1", "reset capture", cap_value, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R10: main-count compare with set action (ctrl 0x0E)
        ctrl_word = 7'h0E;
        main_cnt = 98;
        wr_cmp(100);
        step(99, 0);
        chk("R3", "no event before match", cc_event, 0);
        step(100, 0);
        chk("R3", "event on reaching value", cc_event, 1);
        chk("R7", "set action drives high", cc_out, 1);
        step(100, 0);
        chk("R4", "held count silent", cc_event, 0);
        chk("R7", "set level kept", cc_out, 1);

        // R4: writing the compare value onto a count that does not move
        step(200, 0);
        wr_cmp(200);
        chk("R4", "write-equal silent a", cc_event, 0);
        step(200, 0);
        chk("R4", "write-equal silent b", cc_event, 0);
        step(201, 0);
        step(200, 0);
        chk("R4", "fires after stepping back", cc_event, 1);

        // R7 clear (ctrl 0x0A)
        ctrl_word = 7'h0A;
        step(201, 0);
        step(200, 0);
        chk("R7", "clear drives low", cc_out, 0);

        // R7 toggle (ctrl 0x06)
        ctrl_word = 7'h06;
        step(201, 0);
        step(200, 0);
        chk("R7", "toggle to high", cc_out, 1);
        step(201, 0);
        chk("R7", "toggle keeps level", cc_out, 1);
        step(200, 0);
        chk("R7", "toggle to low", cc_out, 0);

        // R5 / R6: pre-count base with pulse (ctrl 0x12), upper bits ignored
        ctrl_word = 7'h12;
        pre_cnt = 15'h122;
        wr_cmp(32'hABCD_0123);
        step(200, 15'h123);
        chk("R5", "pre-count match event", cc_event, 1);
        chk("R6", "pulse high", cc_out, 1);
        step(200, 15'h123);
        chk("R6", "pulse one clock", cc_out, 0);
        step(32'hABCD_0123, 15'h100);
        chk("R5", "main count ignored in pre base", cc_event, 0);

        // R2: function off and spare function
        step(1, 0);
        ctrl_word = 7'h0E;
        step(32'hABCD_0123, 0);
        chk("R7", "set before off", cc_out, 1);
        ctrl_word = 7'h0C;
        step(1, 0);
        chk("R2", "off pin low", cc_out, 0);
        step(32'hABCD_0123, 0);
        chk("R2", "off no event", cc_event, 0);
        ctrl_word = 7'h0F;
        step(1, 0);
        step(32'hABCD_0123, 0);
        chk("R2", "spare no event", cc_event, 0);
        chk("R2", "spare pin low", cc_out, 0);

        // R8: rising capture (ctrl 0x01), three-edge latency
        ctrl_word = 7'h01;
        main_cnt = 777;
        cap_pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8", "no event before third edge", cc_event, 0);
        @(negedge clk);
        chk("R8", "rising event", cc_event, 1);
        chk("R8", "rising value", cap_value, 777);
        chk("R2", "capture mode pin low", cc_out, 0);
        @(negedge clk);
        chk("R8", "event one clock", cc_event, 0);
        main_cnt = 778;
        cap_pin = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R8", "falling ignored in rising mode", cc_event, 0);
        end
        chk("R8", "value kept", cap_value, 777);

        // R8: falling capture (ctrl 0x21)
        ctrl_word = 7'h21;
        main_cnt = 888;
        cap_pin = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R8", "rising ignored in falling mode", cc_event, 0);
        end
        cap_pin = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8", "falling event", cc_event, 1);
        chk("R8", "falling value", cap_value, 888);

        // R8: both edges (ctrl 0x41)
        ctrl_word = 7'h41;
        main_cnt = 999;
        cap_pin = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8", "both: rising value", cap_value, 999);
        main_cnt = 1000;
        cap_pin = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8", "both: falling value", cap_value, 1000);
        chk("R8", "both: falling event", cc_event, 1);

        // R9: edge none (ctrl 0x61)
        ctrl_word = 7'h61;
        main_cnt = 4242;
        cap_pin = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R9", "none: no event", cc_event, 0);
        end
        cap_pin = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R9", "none: value kept", cap_value, 1000);
        end

        summary();
    end

endmodule